// File: doc/BRIEF.md
# BCD Calendar Date Counter

This block holds a calendar date as packed BCD digits: a two-digit day, a two-digit month and a four-digit year. A time-of-day counter elsewhere issues a one-cycle day pulse at midnight. On that pulse the date moves forward one day. The day limit depends on the month and, for February, on a Gregorian leap-year test taken directly from the BCD year digits.

While the load control is high, the date takes its value from parallel BCD inputs. Counting resumes when load goes low. Everything is synchronous to one system clock, and the day pulse acts as a clock enable.

Top module: `bcd_date_counter`

## Requirements
- R1: After the active-low reset, the outputs read day 8'h01, month 8'h01 and year 16'h2000. Each byte or halfword holds BCD digits with the most significant digit in the top nibble.
- R2: While `load` is high, the next clock edge copies `set_day`, `set_month` and `set_year` to the outputs. This happens even if `day_tick` is also high.
- R3: With `load` low and `day_tick` low, the date does not change.
- R4: A day pulse on a day below the month's limit adds one to the day in BCD. The units digit carries into the tens digit after 9, for example 09 becomes 10 and 19 becomes 20.
- R5: Months 04, 06, 09 and 11 end on day 30. A day pulse on that day gives day 01 of the next month.
- R6: The remaining months other than 02 end on day 31. Day 30 advances to 31, and 31 advances to 01 of the next month.
- R7: February ends on day 29 in a leap year and on day 28 otherwise. When the last two year digits are not 00, the year is a leap year if those two digits form a multiple of 4.
- R8: When the last two year digits are 00, the year is a leap year only if the first two digits form a multiple of 4. So 2000 and 2400 are leap years, while 1900 and 2100 are not.
- R9: A day pulse on 31 December gives 01 January and adds one to the year in BCD, for example 1999 becomes 2000.
- R10: A day pulse on 31 December 9999 gives 01 January 0000.
- R11: A preset day at or beyond the month's limit (for example 31 in month 06, or 30 in February) gives day 01 of the next month on the next day pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load | input | 1 | Preset control; when high, the date follows the set inputs |
| day_tick | input | 1 | One-cycle enable that advances the date one day |
| set_day | input | 8 | Preset day, two BCD digits |
| set_month | input | 8 | Preset month, two BCD digits |
| set_year | input | 16 | Preset year, four BCD digits |
| day | output | 8 | Current day, two BCD digits |
| month | output | 8 | Current month, two BCD digits |
| year | output | 16 | Current year, four BCD digits |

## Verification
The date registers drive the outputs directly, so any wrong internal state is visible at the ports one clock after the edge that caused it. A faulty month-length or leap decision stays hidden until a day pulse arrives on the boundary day. At that point it shows as a wrong day, or as a month that should have advanced and did not, in the cycle after the pulse. For that reason the bench presets each boundary date and applies exactly one pulse. Several leap-rule paths are covered: tens digit odd and even, the century years, and year carry out of 9999.

// File: rtl/bcd_date_counter.sv
module bcd_date_counter #(
  parameter logic [15:0] RST_YEAR = 16'h2000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic        day_tick,
  input  logic [7:0]  set_day,
  input  logic [7:0]  set_month,
  input  logic [15:0] set_year,
  output logic [7:0]  day,
  output logic [7:0]  month,
  output logic [15:0] year
);

  // Two BCD digits form a multiple of 4: even tens need units 0/4/8, odd tens need 2/6
  function automatic logic is_mult4(input logic [7:0] b);
    if (b[4]) return (b[3:0] == 4'd2) || (b[3:0] == 4'd6);
    else      return (b[3:0] == 4'd0) || (b[3:0] == 4'd4) || (b[3:0] == 4'd8);
  endfunction

  function automatic logic [7:0] inc2(input logic [7:0] b);
    if (b[3:0] >= 4'd9) return {b[7:4] + 4'd1, 4'd0};
    else                return {b[7:4], b[3:0] + 4'd1};
  endfunction

  function automatic logic [15:0] inc4(input logic [15:0] y);
    logic [15:0] r;
    logic        c;
    c = 1'b1;
    for (int i = 0; i < 4; i++) begin
      if (c && y[4*i +: 4] >= 4'd9) begin
        r[4*i +: 4] = 4'd0;
      end else begin
        r[4*i +: 4] = y[4*i +: 4] + {3'd0, c};
        c = 1'b0;
      end
    end
    return r;
  endfunction

  logic       leap;
  logic [7:0] last_day;
  logic       month_end, year_end;

  assign leap = (year[7:0] == 8'h00) ? is_mult4(year[15:8]) : is_mult4(year[7:0]);

  always_comb begin
    case (month)
      8'h02:                      last_day = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: last_day = 8'h30;
      default:                    last_day = 8'h31;
    endcase
  end

  assign month_end = day >= last_day;
  assign year_end  = month >= 8'h12;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      day   <= 8'h01;
      month <= 8'h01;
      year  <= RST_YEAR;
    end else if (load) begin
      day   <= set_day;
      month <= set_month;
      year  <= set_year;
    end else if (day_tick) begin
      if (!month_end) begin
        day <= inc2(day);
      end else begin
        day <= 8'h01;
        if (!year_end) begin
          month <= inc2(month);
        end else begin
          month <= 8'h01;
          year  <= inc4(year);
        end
      end
    end
  end

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (day == $past(set_day) && month == $past(set_month) && year == $past(set_year))); // R2
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !day_tick) |=> ($stable(day) && $stable(month) && $stable(year))); // R3
  AST_DAY_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && day_tick) |=> (day != 8'h00)); // R4
  AST_SHORT_MONTH: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && day_tick && month == 8'h04 && day == 8'h30) |=> (day == 8'h01 && month == 8'h05)); // R5
  AST_FEB_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && day_tick && month == 8'h02 && day == 8'h29) |=> (day == 8'h01 && month == 8'h03)); // R7
  AST_NEW_YEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && day_tick && month == 8'h12 && day == 8'h31) |=> (day == 8'h01 && month == 8'h01 && year != $past(year))); // R9

endmodule

// File: tb/tb_bcd_date_counter.sv
module tb_bcd_date_counter;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        load = 0;
  logic        day_tick = 0;
  logic [7:0]  set_day = 0;
  logic [7:0]  set_month = 0;
  logic [15:0] set_year = 0;
  logic [7:0]  day, month;
  logic [15:0] year;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  bcd_date_counter dut (.*);

  // {req, preset day, month, year, expected day, month, year after one pulse}
  localparam logic [71:0] VEC [18] = '{
    {8'd4,  8'h09, 8'h03, 16'h2024, 8'h10, 8'h03, 16'h2024}, // R4
    {8'd4,  8'h19, 8'h07, 16'h2023, 8'h20, 8'h07, 16'h2023}, // R4
    {8'd5,  8'h30, 8'h04, 16'h2023, 8'h01, 8'h05, 16'h2023}, // R5
    {8'd5,  8'h30, 8'h11, 16'h2023, 8'h01, 8'h12, 16'h2023}, // R5
    {8'd6,  8'h30, 8'h01, 16'h2023, 8'h31, 8'h01, 16'h2023}, // R6
    {8'd6,  8'h31, 8'h08, 16'h2023, 8'h01, 8'h09, 16'h2023}, // R6
    {8'd7,  8'h28, 8'h02, 16'h2024, 8'h29, 8'h02, 16'h2024}, // R7
    {8'd7,  8'h29, 8'h02, 16'h2024, 8'h01, 8'h03, 16'h2024}, // R7
    {8'd7,  8'h28, 8'h02, 16'h2023, 8'h01, 8'h03, 16'h2023}, // R7
    {8'd7,  8'h28, 8'h02, 16'h2012, 8'h29, 8'h02, 16'h2012}, // R7
    {8'd8,  8'h28, 8'h02, 16'h1900, 8'h01, 8'h03, 16'h1900}, // R8
    {8'd8,  8'h28, 8'h02, 16'h2000, 8'h29, 8'h02, 16'h2000}, // R8
    {8'd8,  8'h28, 8'h02, 16'h2100, 8'h01, 8'h03, 16'h2100}, // R8
    {8'd8,  8'h28, 8'h02, 16'h2400, 8'h29, 8'h02, 16'h2400}, // R8
    {8'd9,  8'h31, 8'h12, 16'h1999, 8'h01, 8'h01, 16'h2000}, // R9
    {8'd10, 8'h31, 8'h12, 16'h9999, 8'h01, 8'h01, 16'h0000}, // R10
    {8'd11, 8'h31, 8'h06, 16'h2023, 8'h01, 8'h07, 16'h2023}, // R11
    {8'd11, 8'h30, 8'h02, 16'h2023, 8'h01, 8'h03, 16'h2023}  // R11
  };

  task automatic check(input int req, input logic [31:0] exp);
    checks++;
    if ({day, month, year} !== exp) begin
      errors++;
      $display("FAIL R%0d actual %h expected %h", req, {day, month, year}, exp);
    end
  endtask

  task automatic preset(input logic [7:0] d, input logic [7:0] m, input logic [15:0] y);
    @(negedge clk); load = 1; set_day = d; set_month = m; set_year = y;
    @(negedge clk); load = 0;
  endtask

  task automatic pulse();
    @(negedge clk); day_tick = 1;
    @(negedge clk); day_tick = 0;
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    check(1, {8'h01, 8'h01, 16'h2000}); // R1 reset state
    rst_n = 1;
    @(negedge clk);
    check(1, {8'h01, 8'h01, 16'h2000}); // R1

    for (int i = 0; i < 18; i++) begin
      preset(VEC[i][63:56], VEC[i][55:48], VEC[i][47:32]);
      pulse();
      check(int'(VEC[i][71:64]), VEC[i][31:0]);
    end

    // R2: load beats a simultaneous pulse
    @(negedge clk); load = 1; day_tick = 1; set_day = 8'h15; set_month = 8'h05; set_year = 16'h2031;
    @(negedge clk);
    check(2, {8'h15, 8'h05, 16'h2031});
    @(negedge clk);
    check(2, {8'h15, 8'h05, 16'h2031});
    load = 0; day_tick = 0;

    // R3: no pulse, no change
    repeat (5) @(negedge clk);
    check(3, {8'h15, 8'h05, 16'h2031});

    // R7: run across leap February end
    preset(8'h27, 8'h02, 16'h2024);
    pulse(); pulse(); pulse();
    check(7, {8'h01, 8'h03, 16'h2024});

    // R4: consecutive pulses with digit carry
    preset(8'h08, 8'h10, 16'h2024);
    @(negedge clk); day_tick = 1;
    @(negedge clk);
    @(negedge clk); day_tick = 0;
    check(4, {8'h10, 8'h10, 16'h2024});

    // R1: reset mid-run
    rst_n = 0;
    @(negedge clk);
    check(1, {8'h01, 8'h01, 16'h2000});
    rst_n = 1;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule